// File: doc/BRIEF.md
# Host Data Buffer with Service Request and Interrupt Logic

This block holds compressed data words in transit between a video coding core and a host bus. The host reads the words out when the core encodes, and writes words in for the core to take when it decodes. One queue serves both directions. A direction input, `encode`, tells the block which way data is moving. The queue holds 512 words of 32 bits and keeps track of its own fill level. It compares that level against a service threshold, and the meaning of that threshold depends on the direction. When the host needs to act, the block raises a dedicated request pin.

A 16-bit control/status word gathers seven event conditions:
- last code seen
- statistics ready
- queue stop
- service request
- queue error
- video format error
- memory error

Each condition has its own enable bit. The interrupt line is the OR of every condition whose enable is set. Six of the conditions are sticky, and the host clears them by writing a 1 to their bit. The memory-error bit follows its live source and clears by itself when the fault goes away.

Top module: `host_fifo_irq`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty. The level reads 0, `empty`=1 and `full`=0. The whole control/status word reads 0 and `irq` is 0.
- R2: Words accepted by a write come out of reads in the same order. A read is accepted only when the queue is not empty, and its word appears on `rd_data` after the clock edge that accepts it. The queue holds exactly 512 words, and `full` is 1 at level 512.
- R3: A write while `full` is 1 is dropped, and a read while `empty` is 1 is ignored. Neither one changes the level, the stored data or `rd_data`. Either attempt sets the queue-error status bit, bit 12.
- R4: The service threshold is `lvl_code`×32 words. With `encode`=1, `srq` is high whenever level ≥ threshold (a nearly-full request).
- R5: With `encode`=0, `srq` is high whenever level ≤ threshold (a nearly-empty request).
- R6: When `srq` is high at a clock edge, status bit 11 is set after that edge. The bit stays set when `srq` later falls.
- R7: A one-cycle pulse on an event input sets its sticky status bit after that edge:
  - `ev_last_code` sets bit 8
  - `ev_stats_ready` sets bit 9
  - `ev_fifo_stop` sets bit 10
  - `ev_fmt_err` sets bit 13
- R8: A host write (`reg_wr`=1) loads the enable bits 6:0 from `reg_wdata[6:0]`. The enables are ordered like the status bits 8..14. The same write clears each sticky status bit in 8..13 whose `reg_wdata` bit is 1. A set condition in the same cycle overrides the clear. Bits 7 and 15 read 0.
- R9: Status bit 14 shows the `mem_err` input as sampled at the previous edge. Writing 1 to bit 14 has no effect on it, and it falls again without any host write.
- R10: `irq` is 1 exactly when some status bit 8+i and its enable bit i are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| encode | input | 1 | 1: nearly-full threshold; 0: nearly-empty threshold |
| lvl_code | input | 4 | Service threshold code, scaled by 32 |
| wr_en | input | 1 | Push request |
| wr_data | input | 32 | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | 32 | Last popped word |
| level | output | 10 | Number of words held |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| srq | output | 1 | Service request pin |
| ev_last_code | input | 1 | Last-code event pulse |
| ev_stats_ready | input | 1 | Statistics-ready event pulse |
| ev_fifo_stop | input | 1 | Queue-stop event pulse |
| ev_fmt_err | input | 1 | Video format error pulse |
| mem_err | input | 1 | Live memory-error condition |
| reg_wr | input | 1 | Host write to the control/status word |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Control/status word: enables 6:0, status 14:8 |
| irq | output | 1 | Host interrupt line |

## Verification
The hardest state to reach from the ports is a completely full queue held at the nearly-full threshold while a further push arrives. The same write may also try to clear the error bit in that cycle. To set this up, the stimulus runs a long directed write phase up to 512 words and then issues the overflow push together with clears. The mirror case is an underflow pop in decode mode.

Random phases bias pushes over pops, or pops over pushes. This sweeps the level across every threshold code in both directions while host writes and event pulses arrive at random.

// File: rtl/hfifo_pkg.sv
// Package: shared status-bit indices for the host buffer block.
// Assumes condition i is enabled by bit i and reported in bit 8+i.
package hfifo_pkg;
    localparam int N_COND   = 7;
    localparam int STAT_OFS = 8;
    localparam int C_LCODE  = 0;
    localparam int C_STATS  = 1;
    localparam int C_FSTOP  = 2;
    localparam int C_SRQ    = 3;
    localparam int C_FERR   = 4;
    localparam int C_FMT    = 5;
    localparam int C_MERR   = 6;
endpackage

// File: rtl/hfifo_store.sv
// Module: word queue with level tracking.
// Assumes DEPTH is a power of two; storage is not reset, only pointers.
module hfifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rd_data,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       full,
    output logic                       empty,
    output logic                       bad_access
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              push, pop;

    assign full       = (level == (AW+1)'(DEPTH));
    assign empty      = (level == '0);
    assign push       = wr_en && !full;
    assign pop        = rd_en && !empty;
    assign bad_access = (wr_en && full) || (rd_en && empty);

    // Store an accepted word.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Advance pointers, level and output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            rd_data <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop) begin
                rptr    <= rptr + 1'b1;
                rd_data <= mem[rptr];
            end
            level <= level + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (level == $past(level)));
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> (level == $past(level) && $stable(rd_data)));
endmodule

// File: rtl/hfifo_srq.sv
// Module: service threshold compare.
// Assumes the threshold is the code scaled by SCALE; direction flips the sense.
module hfifo_srq #(
    parameter int LVL_W  = 10,
    parameter int CODE_W = 4,
    parameter int SCALE  = 32
) (
    input  logic [LVL_W-1:0]  level,
    input  logic              encode,
    input  logic [CODE_W-1:0] code,
    output logic              srq
);
    localparam int TH_W = CODE_W + $clog2(SCALE);
    logic [LVL_W-1:0] thresh;

    // Scale the code and compare in the active direction.
    always_comb begin
        thresh = LVL_W'(TH_W'(code) * TH_W'(SCALE));
        srq    = encode ? (level >= thresh) : (level <= thresh);
    end
endmodule

// File: rtl/hfifo_irq.sv
// Module: enable/status word with write-one-to-clear and interrupt OR.
// Assumes conditions other than memory error are sticky; set beats clear.
module hfifo_irq
    import hfifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_COND-1:0] ev_set,
    input  logic              merr_live,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq
);
    logic [N_COND-1:0] en_q, st_q;

    // Update enables and status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (reg_wr) en_q <= reg_wdata[N_COND-1:0];
            for (int i = 0; i < N_COND; i++) begin
                if (i == C_MERR)
                    st_q[i] <= merr_live;
                else
                    st_q[i] <= ev_set[i] ||
                               (st_q[i] && !(reg_wr && reg_wdata[STAT_OFS+i]));
            end
        end
    end

    // Assemble the word and the interrupt line.
    always_comb begin
        reg_rdata = {1'b0, st_q, 1'b0, en_q};
        irq       = |(st_q & en_q);
    end

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[C_FSTOP] && !(reg_wr && reg_wdata[STAT_OFS+C_FSTOP])) |=> st_q[C_FSTOP]);
    // R9
    merr_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !merr_live |=> !reg_rdata[STAT_OFS+C_MERR]);
endmodule

// File: rtl/host_fifo_irq.sv
// Module: top of the host data buffer with service request and interrupt.
// Assumes single clock, synchronous active-low reset.
module host_fifo_irq
    import hfifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    parameter int CODE_W = 4,
    parameter int SCALE  = 32,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              encode,
    input  logic [CODE_W-1:0] lvl_code,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              srq,
    input  logic              ev_last_code,
    input  logic              ev_stats_ready,
    input  logic              ev_fifo_stop,
    input  logic              ev_fmt_err,
    input  logic              mem_err,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq
);
    logic              bad_access;
    logic [N_COND-1:0] ev_set;

    hfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .level(level), .full(full),
        .empty(empty), .bad_access(bad_access)
    );

    hfifo_srq #(.LVL_W(LVL_W), .CODE_W(CODE_W), .SCALE(SCALE)) u_srq (
        .level(level), .encode(encode), .code(lvl_code), .srq(srq)
    );

    // Gather the set conditions in status-bit order.
    always_comb begin
        ev_set          = '0;
        ev_set[C_LCODE] = ev_last_code;
        ev_set[C_STATS] = ev_stats_ready;
        ev_set[C_FSTOP] = ev_fifo_stop;
        ev_set[C_SRQ]   = srq;
        ev_set[C_FERR]  = bad_access;
        ev_set[C_FMT]   = ev_fmt_err;
    end

    hfifo_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .merr_live(mem_err),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // R6
    srq_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srq |=> reg_rdata[STAT_OFS+C_SRQ]);
    // R3
    ferr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> reg_rdata[STAT_OFS+C_FERR]);
    // R10
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((reg_rdata[14:8] & reg_rdata[6:0]) != 7'd0));
endmodule

// File: tb/test_host_fifo_irq.sv
module test_host_fifo_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        encode = 1'b1;
    logic [3:0]  lvl_code = 4'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [9:0]  level;
    logic        full, empty, srq, irq;
    logic        ev_lc = 0, ev_st = 0, ev_fs = 0, ev_fm = 0, merr = 0;
    logic        reg_wr = 0;
    logic [15:0] reg_wdata = '0, reg_rdata;

    int checks = 0, fails = 0;
    bit done = 0;

    // model state
    logic [31:0] q[$];
    logic [6:0]  m_en = '0, m_st = '0;
    logic [31:0] m_rd = '0;

    always #2.5 clk = ~clk;

    host_fifo_irq i_host_fifo_irq (
        .clk(clk), .rst_n(rst_n), .encode(encode), .lvl_code(lvl_code),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .level(level), .full(full), .empty(empty), .srq(srq),
        .ev_last_code(ev_lc), .ev_stats_ready(ev_st), .ev_fifo_stop(ev_fs),
        .ev_fmt_err(ev_fm), .mem_err(merr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic bit exp_srq(int lvl, bit enc, int code);
        int th = code * 32;
        return enc ? (lvl >= th) : (lvl <= th);
    endfunction

    function automatic logic [15:0] exp_word();
        return {1'b0, m_st, 1'b0, m_en};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk("R2 level", 32'(level), 32'(q.size()));
        chk("R2 full", 32'(full), 32'(q.size() == 512));
        chk("R2 empty", 32'(empty), 32'(q.size() == 0));
        chk(encode ? "R4 srq" : "R5 srq", 32'(srq), 32'(exp_srq(q.size(), encode, lvl_code)));
        chk("R8 word", 32'(reg_rdata), 32'(exp_word()));
        chk("R10 irq", 32'(irq), 32'(|(m_st & m_en)));
        chk("R2 rd_data", rd_data, m_rd);
    endtask

    // One clock: model update from pre-edge state, then check at negedge.
    task automatic cycle();
        bit pre_srq = exp_srq(q.size(), encode, lvl_code);
        bit werr = wr_en && (q.size() == 512);
        bit rerr = rd_en && (q.size() == 0);
        bit dopush = wr_en && !werr;
        bit dopop  = rd_en && !rerr;
        logic [6:0] set = {1'b0, ev_fm, werr | rerr, pre_srq, ev_fs, ev_st, ev_lc};
        logic [6:0] clr = reg_wr ? reg_wdata[14:8] : 7'd0;
        @(posedge clk);
        if (!rst_n) begin
            q.delete(); m_en = '0; m_st = '0; m_rd = '0;
        end else begin
            if (dopop) m_rd = q.pop_front();
            if (dopush) q.push_back(wr_data);
            for (int i = 0; i < 6; i++) m_st[i] = set[i] | (m_st[i] & ~clr[i]);
            m_st[6] = merr;
            if (reg_wr) m_en = reg_wdata[6:0];
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic idle_in();
        wr_en = 0; rd_en = 0; reg_wr = 0; reg_wdata = '0;
        ev_lc = 0; ev_st = 0; ev_fs = 0; ev_fm = 0;
    endtask

    initial begin
        int unsigned dummy;
        dummy = $urandom(32'h5eed_1234);
        @(negedge clk);
        cycle(); cycle();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 level", 32'(level), 0);
        chk("R1 empty", 32'(empty), 1);
        chk("R1 full", 32'(full), 0);
        chk("R1 word", 32'(reg_rdata), 0);
        chk("R1 irq", 32'(irq), 0);

        // R3 underflow in decode mode
        encode = 0; lvl_code = 4'd2;
        rd_en = 1; cycle(); idle_in();
        chk("R3 underflow ferr", 32'(reg_rdata[12]), 1);
        cycle();
        // R8 write-one-to-clear, enable queue error only
        reg_wr = 1; reg_wdata = 16'h1810; cycle(); idle_in();
        chk("R8 cleared ferr", 32'(reg_rdata[12]), 0);
        // R6 srq sticky: level 0 <= 64 keeps srq set in decode
        chk("R6 srq bit", 32'(reg_rdata[11]), 1);

        // R2 fill to full in encode mode, threshold 480 (R4)
        encode = 1; lvl_code = 4'd15;
        for (int i = 0; i < 512; i++) begin
            wr_en = 1; wr_data = $urandom; cycle();
        end
        idle_in();
        chk("R2 full at 512", 32'(full), 1);
        chk("R4 srq at full", 32'(srq), 1);
        // R3 overflow push with simultaneous clear: set wins (R8)
        wr_en = 1; wr_data = 32'hdead_beef; reg_wr = 1; reg_wdata = 16'h1010;
        cycle(); idle_in();
        chk("R3 overflow ferr", 32'(reg_rdata[12]), 1);
        chk("R3 level kept", 32'(level), 512);
        chk("R10 irq from ferr", 32'(irq), 1);

        // R7 event pulses
        ev_lc = 1; ev_st = 1; ev_fs = 1; ev_fm = 1; cycle(); idle_in();
        chk("R7 events", 32'({reg_rdata[13], reg_rdata[10:8]}), 32'hf);
        // R9 memory error follows live input, ignores clear
        merr = 1; cycle();
        reg_wr = 1; reg_wdata = 16'h4040; cycle(); idle_in();
        chk("R9 merr held", 32'(reg_rdata[14]), 1);
        chk("R10 irq merr", 32'(irq), 1);
        merr = 0; cycle();
        chk("R9 merr recover", 32'(reg_rdata[14]), 0);

        // drain in decode mode, threshold 128 (R5)
        encode = 0; lvl_code = 4'd4;
        for (int i = 0; i < 520; i++) begin
            rd_en = 1; cycle();
        end
        idle_in();
        chk("R5 srq empty", 32'(srq), 1);

        // random phases
        for (int ph = 0; ph < 12; ph++) begin
            int bias = (ph % 2 == 0) ? 75 : 25;
            encode = $urandom_range(0, 1);
            lvl_code = 4'($urandom_range(0, 15));
            for (int n = 0; n < 900; n++) begin
                wr_en = ($urandom_range(0, 99) < bias);
                rd_en = ($urandom_range(0, 99) < 100 - bias);
                wr_data = $urandom;
                reg_wr = ($urandom_range(0, 19) == 0);
                reg_wdata = 16'($urandom);
                ev_lc = ($urandom_range(0, 49) == 0);
                ev_st = ($urandom_range(0, 49) == 0);
                ev_fs = ($urandom_range(0, 49) == 0);
                ev_fm = ($urandom_range(0, 49) == 0);
                merr = ($urandom_range(0, 29) == 0);
                if (n % 300 == 0) lvl_code = 4'($urandom_range(0, 15));
                cycle();
            end
        end
        idle_in(); merr = 0;
        cycle();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule